// File: doc/BRIEF.md
# USB Receive Endpoint Handshake Controller

This block is the receive-side control of a single endpoint in a low-speed USB device. It holds one software-writable register and watches decoded events from the serial interface engine. The register has a receive status, an expected data toggle, a control-endpoint flag, an endpoint number and a transfer-complete flag. For each OUT or SETUP token the block decides whether the transaction is meant for this endpoint. When the data packet that follows ends, it picks the handshake to return, updates the toggle and status, and may raise the transfer-complete flag.

After a good reception the endpoint parks itself in NAK. The received data therefore stays safe until software re-arms the endpoint by writing the status back to valid. A SETUP packet always restarts the toggle sequence at DATA0. Bit-level decoding, CRC computation and the data buffer sit outside this block and reach it only as pulses and flags. The handshake leaves as a one-cycle strobe and has no back-pressure: the serial engine must take it in the cycle it appears, because a USB handshake slot cannot be delayed. Likewise, tokens and end-of-packet pulses are accepted in the cycle they are presented.

Top module: `usb_rx_ep_ctrl`

## Requirements
- R1: After `rst_n` low or a one-cycle `bus_reset`, every register field reads 0 (status disabled). A token latched before a bus reset produces no handshake.
- R2: A token whose endpoint number differs from the register's endpoint field produces no handshake strobe and changes no register field.
- R3: A SETUP token reaches this endpoint only when the control flag (register bit 3) is 1. Otherwise the following packet gets no strobe.
- R4: With a good CRC, the status decides the handshake code: disabled (00) gives code none (00), stall (01) gives STALL (11), NAK (10) gives NAK (10). None of these changes the toggle, status or flag.
- R5: In the valid status (11), a good packet whose data PID (`pkt_data1`) equals the expected toggle (bit 2) gets ACK (01). The toggle flips, the status becomes NAK (10) and the flag (bit 8) is set.
- R6: In the valid status, a good packet whose data PID differs from the expected toggle gets ACK. The toggle, status and flag are left unchanged.
- R7: A SETUP to a valid control endpoint first clears the expected toggle and then applies R5/R6. A DATA0 SETUP therefore leaves the toggle at 1, the status at NAK and the flag set.
- R8: A packet ending with `pkt_crc_ok` low gets code none and changes no register field.
- R9: `hs_valid` rises in the cycle after the `pkt_end` that completes an addressed transaction and lasts exactly one cycle. The register fields reflect the update in that same cycle.
- R10: The software write layout is status [1:0], toggle [2], control [3], endpoint [7:4], flag [8]. Writing 0 to bit 8 clears the flag and writing 1 has no effect. When a good packet reaches a valid endpoint on the same cycle as a write, the hardware values of status, toggle and flag win, while control and endpoint take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Synchronous USB bus reset pulse |
| reg_wr_en | input | 1 | Software register write strobe |
| reg_wr_data | input | EP_W+5 | Software write value |
| reg_rd_data | output | EP_W+5 | Current register contents |
| tok_valid | input | 1 | Decoded OUT/SETUP token pulse |
| tok_setup | input | 1 | Token is SETUP (1) or OUT (0) |
| tok_ep | input | EP_W | Token endpoint number |
| pkt_end | input | 1 | End of data packet pulse |
| pkt_crc_ok | input | 1 | Data packet CRC was correct |
| pkt_data1 | input | 1 | Data PID was DATA1 (1) or DATA0 (0) |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
The bench targets the duplicate-packet case. A design that flipped the toggle or raised the flag on a mismatched PID would lose the next real packet, and one that NAKed it would make the host retry forever. It checks that a SETUP arriving with the toggle at 1 is still accepted as DATA0 and leaves the toggle at 1; a design that skipped the clear would treat it as a duplicate. It also drives a software write in the same cycle as a good reception, and a bus reset between a token and its packet. A design that let software override the NAK, or that kept the stale token, would show the wrong status or a stray handshake.

// File: rtl/usb_rxep_pkg.sv
package usb_rxep_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'b00,
    ST_STALL = 2'b01,
    ST_NAK   = 2'b10,
    ST_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;
endpackage

// File: rtl/usb_rxep_match.sv
module usb_rxep_match #(
  parameter int EP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            tok_valid,
  input  logic            tok_setup,
  input  logic [EP_W-1:0] tok_ep,
  input  logic [EP_W-1:0] my_ep,
  input  logic            is_ctrl,
  input  logic            pkt_end,
  output logic            hit,
  output logic            hit_setup
);
  logic addr_eq;
  logic kind_ok;

  assign addr_eq = (tok_ep == my_ep);
  assign kind_ok = !tok_setup || is_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit       <= 1'b0;
      hit_setup <= 1'b0;
    end else if (bus_reset) begin
      hit       <= 1'b0;
      hit_setup <= 1'b0;
    end else if (tok_valid) begin
      hit       <= addr_eq && kind_ok;
      hit_setup <= tok_setup;
    end else if (pkt_end) begin
      hit       <= 1'b0;
      hit_setup <= 1'b0;
    end
  end

  // R3: a SETUP token never selects a non-control endpoint
  a_r3_setup_needs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_setup && !is_ctrl |=> !hit);

  // R2: a token for another endpoint never selects this one
  a_r2_ep_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && (tok_ep != my_ep) |=> !hit);
endmodule

// File: rtl/usb_rxep_decide.sv
module usb_rxep_decide
  import usb_rxep_pkg::*;
(
  input  rx_stat_e stat,
  input  logic     tog,
  input  logic     is_setup,
  input  logic     crc_ok,
  input  logic     pid1,
  output hs_code_e code,
  output logic     hw_upd,
  output logic     nxt_tog,
  output rx_stat_e nxt_stat,
  output logic     set_flag
);
  logic eff_tog;
  logic pid_match;

  // SETUP data always starts at DATA0
  assign eff_tog   = is_setup ? 1'b0 : tog;
  assign pid_match = (pid1 == eff_tog);

  always_comb begin
    code     = HS_NONE;
    hw_upd   = 1'b0;
    nxt_tog  = tog;
    nxt_stat = stat;
    set_flag = 1'b0;
    if (crc_ok) begin
      unique case (stat)
        ST_OFF:   code = HS_NONE;
        ST_STALL: code = HS_STALL;
        ST_NAK:   code = HS_NAK;
        ST_VALID: begin
          code   = HS_ACK;
          hw_upd = 1'b1;
          if (pid_match) begin
            nxt_tog  = ~eff_tog;
            nxt_stat = ST_NAK;
            set_flag = 1'b1;
          end else begin
            nxt_tog  = eff_tog;
            nxt_stat = ST_VALID;
          end
        end
        default: code = HS_NONE;
      endcase
    end
  end

  // R6: only an acknowledged packet may complete a transfer
  always_comb begin
    a_r6_flag_needs_ack: assert (!set_flag || code == HS_ACK);
  end
endmodule

// File: rtl/usb_rx_ep_ctrl.sv
module usb_rx_ep_ctrl
  import usb_rxep_pkg::*;
#(
  parameter int EP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            reg_wr_en,
  input  logic [EP_W+4:0] reg_wr_data,
  output logic [EP_W+4:0] reg_rd_data,
  input  logic            tok_valid,
  input  logic            tok_setup,
  input  logic [EP_W-1:0] tok_ep,
  input  logic            pkt_end,
  input  logic            pkt_crc_ok,
  input  logic            pkt_data1,
  output logic            hs_valid,
  output logic [1:0]      hs_code
);
  localparam int FLAG_BIT = EP_W + 4;
  localparam int CTRL_BIT = 3;
  localparam int TOG_BIT  = 2;

  rx_stat_e        stat_q;
  logic            tog_q;
  logic            ctrl_q;
  logic [EP_W-1:0] ep_q;
  logic            flag_q;

  logic     pend_hit;
  logic     pend_setup;
  logic     fire;
  hs_code_e dec_code;
  logic     hw_upd;
  logic     nxt_tog;
  rx_stat_e nxt_stat;
  logic     set_flag;

  usb_rxep_match #(.EP_W(EP_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .tok_valid (tok_valid),
    .tok_setup (tok_setup),
    .tok_ep    (tok_ep),
    .my_ep     (ep_q),
    .is_ctrl   (ctrl_q),
    .pkt_end   (pkt_end),
    .hit       (pend_hit),
    .hit_setup (pend_setup)
  );

  usb_rxep_decide u_decide (
    .stat     (stat_q),
    .tog      (tog_q),
    .is_setup (pend_setup),
    .crc_ok   (pkt_crc_ok),
    .pid1     (pkt_data1),
    .code     (dec_code),
    .hw_upd   (hw_upd),
    .nxt_tog  (nxt_tog),
    .nxt_stat (nxt_stat),
    .set_flag (set_flag)
  );

  assign fire = pkt_end && pend_hit && !bus_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= ST_OFF;
      tog_q    <= 1'b0;
      ctrl_q   <= 1'b0;
      ep_q     <= '0;
      flag_q   <= 1'b0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else if (bus_reset) begin
      stat_q   <= ST_OFF;
      tog_q    <= 1'b0;
      ctrl_q   <= 1'b0;
      ep_q     <= '0;
      flag_q   <= 1'b0;
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      if (reg_wr_en) begin
        stat_q <= rx_stat_e'(reg_wr_data[1:0]);
        tog_q  <= reg_wr_data[TOG_BIT];
        ctrl_q <= reg_wr_data[CTRL_BIT];
        ep_q   <= reg_wr_data[CTRL_BIT+EP_W:CTRL_BIT+1];
        if (!reg_wr_data[FLAG_BIT]) flag_q <= 1'b0;
      end
      if (fire && hw_upd) begin
        stat_q <= nxt_stat;
        tog_q  <= nxt_tog;
        if (set_flag) flag_q <= 1'b1;
      end
      hs_valid <= fire;
      hs_code  <= fire ? dec_code : HS_NONE;
    end
  end

  assign reg_rd_data = {flag_q, ep_q, ctrl_q, tog_q, stat_q};

  // R9: the handshake strobe is a single cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R9: a strobe only follows an end-of-packet
  a_r9_after_pkt_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_valid) |-> $past(pkt_end));

  // R5: a completed transfer leaves the endpoint in NAK
  a_r5_flag_parks_nak: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> stat_q == ST_NAK && hs_valid && hs_code == HS_ACK);

  // R8: a silent handshake leaves the endpoint state alone
  a_r8_none_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_code == HS_NONE && !$past(reg_wr_en)
      |-> stat_q == $past(stat_q) && tog_q == $past(tog_q) && flag_q == $past(flag_q));

  // R4: STALL is only returned while the endpoint is stalled
  a_r4_stall_state: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && hs_code == HS_STALL && !$past(reg_wr_en) |-> stat_q == ST_STALL);
endmodule

// File: tb/test_usb_rx_ep_ctrl.sv
module test_usb_rx_ep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EP_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_reset = 1'b0;
  logic            reg_wr_en = 1'b0;
  logic [EP_W+4:0] reg_wr_data = '0;
  logic [EP_W+4:0] reg_rd_data;
  logic            tok_valid = 1'b0;
  logic            tok_setup = 1'b0;
  logic [EP_W-1:0] tok_ep = '0;
  logic            pkt_end = 1'b0;
  logic            pkt_crc_ok = 1'b0;
  logic            pkt_data1 = 1'b0;
  logic            hs_valid;
  logic [1:0]      hs_code;

  usb_rx_ep_ctrl #(.EP_W(EP_W)) i_usb_rx_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep),
    .pkt_end(pkt_end), .pkt_crc_ok(pkt_crc_ok), .pkt_data1(pkt_data1),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_run = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;

  // behavioural reference state
  int       m_stat = 0;
  bit       m_tog = 0, m_ctrl = 0, m_flag = 0;
  int       m_ep = 0;
  bit       m_sel = 0, m_sel_setup = 0;
  bit       m_hsv = 0;
  int       m_hsc = 0;

  always @(posedge clk) begin
    bit do_fire;
    int res_stat; bit res_tog; bit res_flag; bit hw; int code;
    if (!rst_n || bus_reset) begin
      m_stat = 0; m_tog = 0; m_ctrl = 0; m_ep = 0; m_flag = 0;
      m_sel = 0; m_sel_setup = 0; m_hsv = 0; m_hsc = 0;
    end else begin
      do_fire = pkt_end && m_sel;
      hw = 0; code = 0;
      res_stat = m_stat; res_tog = m_tog; res_flag = m_flag;
      if (do_fire && pkt_crc_ok) begin
        if (m_stat == 1) code = 3;
        else if (m_stat == 2) code = 2;
        else if (m_stat == 3) begin
          bit expect_pid;
          code = 1; hw = 1;
          expect_pid = m_sel_setup ? 1'b0 : m_tog;
          if (pkt_data1 == expect_pid) begin
            res_tog = !expect_pid; res_stat = 2; res_flag = 1;
          end else begin
            res_tog = expect_pid; res_stat = 3;
          end
        end
      end
      // token latch uses pre-edge register values
      if (tok_valid) begin
        m_sel = (int'(tok_ep) == m_ep) && (!tok_setup || m_ctrl);
        m_sel_setup = tok_setup;
      end else if (pkt_end) begin
        m_sel = 0; m_sel_setup = 0;
      end
      if (reg_wr_en) begin
        m_stat = int'(reg_wr_data[1:0]);
        m_tog  = reg_wr_data[2];
        m_ctrl = reg_wr_data[3];
        m_ep   = int'(reg_wr_data[7:4]);
        if (!reg_wr_data[8]) m_flag = 0;
      end
      if (hw) begin
        m_stat = res_stat; m_tog = res_tog;
        if (res_flag) m_flag = 1;
      end
      m_hsv = do_fire;
      m_hsc = do_fire ? code : 0;
    end
  end

  function automatic int exp_reg();
    return (int'(m_flag) << 8) | (m_ep << 4) | (int'(m_ctrl) << 3) | (int'(m_tog) << 2) | m_stat;
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      n_run++;
      if (hs_valid !== m_hsv || (m_hsv && int'(hs_code) != m_hsc)) begin
        n_fail++;
        $display("FAIL %s: hs_valid/code got %0b/%0d expected %0b/%0d",
                 cur_req, hs_valid, hs_code, m_hsv, m_hsc);
      end
      n_run++;
      if (int'(reg_rd_data) != exp_reg()) begin
        n_fail++;
        $display("FAIL %s: register got %03h expected %03h", cur_req, reg_rd_data, exp_reg());
      end
    end
  end

  task automatic cyc(bit wr = 0, int wd = 0, bit tv = 0, bit ts = 0, int te = 0,
                     bit pe = 0, bit crc = 0, bit p1 = 0, bit br = 0);
    @(posedge clk); #1;
    reg_wr_en = wr; reg_wr_data = wd[EP_W+4:0];
    tok_valid = tv; tok_setup = ts; tok_ep = te[EP_W-1:0];
    pkt_end = pe; pkt_crc_ok = crc; pkt_data1 = p1; bus_reset = br;
  endtask

  task automatic wr_reg(int flag, int ep, int ctrl, int tog, int stat);
    cyc(.wr(1), .wd((flag << 8) | (ep << 4) | (ctrl << 3) | (tog << 2) | stat));
    cyc();
  endtask

  task automatic xfer(bit setup, int ep, bit crc, bit p1);
    cyc(.tv(1), .ts(setup), .te(ep));
    cyc();
    cyc(.pe(1), .crc(crc), .p1(p1));
    cyc(); cyc();
  endtask

  // explicit directed check at the ports
  task automatic expect_reg(string req, int val);
    @(negedge clk);
    n_run++;
    if (int'(reg_rd_data) != val) begin
      n_fail++;
      $display("FAIL %s: register got %03h expected %03h", req, reg_rd_data, val);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checking = 1'b1;
    cur_req = "R1"; expect_reg("R1", 0);

    // R2: wrong endpoint number
    cur_req = "R2"; wr_reg(0, 3, 0, 0, 3);
    xfer(0, 5, 1, 0);
    expect_reg("R2", 'h033);

    // R5: good matching OUT
    cur_req = "R5"; xfer(0, 3, 1, 0);
    expect_reg("R5", 'h136);

    // R4: NAK status
    cur_req = "R4"; xfer(0, 3, 1, 1);
    expect_reg("R4", 'h136);

    // R10: writing 1 to the flag has no effect; writing 0 clears it
    cur_req = "R10"; wr_reg(1, 3, 0, 1, 3);
    expect_reg("R10", 'h137);
    wr_reg(0, 3, 0, 1, 3);
    expect_reg("R10", 'h037);

    // R6: duplicate DATA0 while expecting DATA1
    cur_req = "R6"; xfer(0, 3, 1, 0);
    expect_reg("R6", 'h037);

    // R8: bad CRC
    cur_req = "R8"; xfer(0, 3, 0, 1);
    expect_reg("R8", 'h037);

    // R3: SETUP to a non-control endpoint
    cur_req = "R3"; xfer(1, 3, 1, 0);
    expect_reg("R3", 'h037);

    // R7: SETUP with toggle at 1 on a control endpoint
    cur_req = "R7"; wr_reg(0, 3, 1, 1, 3);
    xfer(1, 3, 1, 0);
    expect_reg("R7", 'h13e);

    // R4: stall and disabled
    cur_req = "R4"; wr_reg(0, 3, 1, 0, 1);
    xfer(0, 3, 1, 0);
    expect_reg("R4", 'h039);
    wr_reg(0, 3, 1, 0, 0);
    xfer(0, 3, 1, 0);
    expect_reg("R4", 'h038);

    // R10: write collides with a good reception; hardware keeps NAK
    cur_req = "R10"; wr_reg(0, 3, 0, 0, 3);
    cyc(.tv(1), .te(3));
    cyc();
    cyc(.wr(1), .wd((1 << 4) | 3), .pe(1), .crc(1), .p1(0));
    cyc(); cyc();
    expect_reg("R10", 'h116);

    // R9: back-to-back pkt_end gives a single strobe
    cur_req = "R9"; wr_reg(0, 3, 0, 0, 3);
    cyc(.tv(1), .te(3));
    cyc(.pe(1), .crc(1), .p1(0));
    cyc(.pe(1), .crc(1), .p1(1));
    cyc(); cyc();
    expect_reg("R9", 'h136);

    // R1: bus reset between token and packet
    cur_req = "R1"; wr_reg(0, 0, 0, 0, 3);
    cyc(.tv(1), .te(0));
    cyc(.br(1));
    cyc(.pe(1), .crc(1), .p1(0));
    cyc(); cyc();
    expect_reg("R1", 0);

    checking = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule